// File: doc/BRIEF.md
# MSI Doorbell Write Port with Device Identifier Capture

This block is a write-only AXI-style slave endpoint for one doorbell register. A message-signalled interrupt arrives as a single-beat write to the doorbell. The block pairs the written event number with the identity of the requester and presents both as a one-cycle event to the interrupt logic behind it.

A build-time parameter selects how the requester identity arrives, and one instance uses only one of these methods. In sideband mode the identity comes from the AW user field. In wide mode the requester writes 64 bits, and the upper 32 bits hold the identity. Writes that do not qualify as doorbell writes still receive a compliant OKAY response and are then dropped. This covers the wrong size, bursts, other offsets, barriers and non-plain snoop types. Reads are answered with zero data and change nothing.

The block decodes only address bits 15:0, so upstream decoding must route only doorbell traffic to it. A registered wakeup output follows the address-valid inputs, so that a clock-gating controller sees a glitch-free request. `DATA_W` must be at least 64.

Top module: `msi_doorbell_port`

## Requirements
- R1: A qualifying write raises `evt_valid` for exactly one cycle. The pulse is in the cycle after the edge on which its last W beat is accepted, and `evt_dev`/`evt_id` carry its payload. A qualifying write has `awlen`=0, the size rule of the mode, `awaddr[15:0]`=`DOORBELL_OFS`, `awsnoop`=0 and `awbar[0]`=0.
- R2: In wide mode (`WIDE_MODE`=1) only `awsize`=3 (8 bytes) qualifies. `evt_id` is the lower 32 bits and `evt_dev` the upper 32 bits of the 64-bit word at the doorbell's byte lane.
- R3: In sideband mode (`WIDE_MODE`=0) only `awsize`=1 (2 bytes) and `awsize`=2 (4 bytes) qualify. `evt_dev` is `awuser` as captured with the address. `evt_id` is the written data, zero-extended from 16 bits for a 2-byte write.
- R4: A write with `awlen`>0 or a size outside the mode's rule gets all of its W beats consumed and an OKAY response, and it produces no event.
- R5: Only `awaddr[15:0]` is decoded. A write to another offset gets OKAY and no event. Setting bits 16 and above does not change the outcome.
- R6: A write with `awbar[0]`=1 (barrier) or `awsnoop`≠0 gets OKAY and no event. Cache, protection and domain inputs have no effect.
- R7: At most two writes are outstanding. `awready` is low while two accepted writes are still without a completed B handshake.
- R8: At most one read is outstanding, and `arready` is low while `rvalid` is high. A read returns `arlen`+1 beats with zero data, `rresp`=0, `rid`=`arid` and `rlast` on the final beat, and it produces no event.
- R9: `wakeup` equals the OR of `awvalid` and `arvalid` registered one clock earlier.
- R10: B responses come back in address-acceptance order with `bid` from `awid` and `bresp`=0 (OKAY). `bvalid` and `bid` hold while `bready` is low.
- R11: After reset `awready` is 1, and `bvalid`, `rvalid`, `evt_valid` and `wakeup` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awid | input | ID_W | Write transaction ID |
| awaddr | input | ADDR_W | Write address |
| awlen | input | 8 | Burst length minus one |
| awsize | input | 3 | Beat size, log2 bytes |
| awcache | input | 4 | Cache attributes (ignored) |
| awprot | input | 3 | Protection attributes (ignored) |
| awsnoop | input | 4 | Snoop type, nonzero filtered |
| awdomain | input | 2 | Shareability domain (ignored) |
| awbar | input | 2 | Barrier flag in bit 0 |
| awuser | input | USER_W | Requester identity in sideband mode |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Byte strobes (ignored) |
| wlast | input | 1 | Last beat of burst |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bid | output | ID_W | Response ID |
| bresp | output | 2 | Response code, always OKAY |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| arid | input | ID_W | Read transaction ID |
| araddr | input | ADDR_W | Read address (ignored) |
| arlen | input | 8 | Read burst length minus one |
| arsize | input | 3 | Read beat size (ignored) |
| arcache | input | 4 | Ignored |
| arprot | input | 3 | Ignored |
| arsnoop | input | 4 | Ignored |
| ardomain | input | 2 | Ignored |
| arbar | input | 2 | Ignored |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rid | output | ID_W | Read response ID |
| rdata | output | DATA_W | Read data, always zero |
| rresp | output | 2 | Read response, always OKAY |
| rlast | output | 1 | Last read beat |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_dev | output | DEV_W | Captured requester identity |
| evt_id | output | 32 | Written event number |
| wakeup | output | 1 | Registered OR of address valids |

## Verification
The bench drives both modes side by side from the same stimulus. Its random writes mix sizes, burst lengths, offsets, high address bits, snoop and barrier codes, so a size rule swapped between modes would show up as events in the wrong instance. A dropped upper-address mask, or a barrier that is not filtered, shows up the same way. A directed test holds `bready` low to fill both write slots. A design with a deeper queue would accept a third address, and one that reorders responses would return the wrong `bid`. Multi-beat reads expose a design that raises `rlast` on the wrong beat or accepts a second read early.

// File: rtl/msi_doorbell_port.sv
module msi_doorbell_port #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int ID_W   = 4,
  parameter int USER_W = 32,
  parameter int DEV_W  = 32,
  parameter bit WIDE_MODE = 1'b0,
  parameter logic [15:0] DOORBELL_OFS = 16'h0040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ID_W-1:0]   awid,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic [7:0]        awlen,
  input  logic [2:0]        awsize,
  input  logic [3:0]        awcache,
  input  logic [2:0]        awprot,
  input  logic [3:0]        awsnoop,
  input  logic [1:0]        awdomain,
  input  logic [1:0]        awbar,
  input  logic [USER_W-1:0] awuser,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  input  logic              wlast,
  output logic              bvalid,
  input  logic              bready,
  output logic [ID_W-1:0]   bid,
  output logic [1:0]        bresp,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ID_W-1:0]   arid,
  input  logic [ADDR_W-1:0] araddr,
  input  logic [7:0]        arlen,
  input  logic [2:0]        arsize,
  input  logic [3:0]        arcache,
  input  logic [2:0]        arprot,
  input  logic [3:0]        arsnoop,
  input  logic [1:0]        ardomain,
  input  logic [1:0]        arbar,
  output logic              rvalid,
  input  logic              rready,
  output logic [ID_W-1:0]   rid,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rlast,
  output logic              evt_valid,
  output logic [DEV_W-1:0]  evt_dev,
  output logic [31:0]       evt_id,
  output logic              wakeup
);
  localparam int STRB_W = DATA_W / 8;
  localparam int LANE_W = $clog2(STRB_W);
  localparam int QD     = 2;

  logic [ID_W-1:0]   aq_id   [QD];
  logic              aq_ok   [QD];
  logic              aq_half [QD];
  logic [DEV_W-1:0]  aq_dev  [QD];
  logic [LANE_W-1:0] aq_lane [QD];
  logic              aq_wp, aq_rp;
  logic [1:0]        aq_n;

  logic [ID_W-1:0]   bq_id [QD];
  logic              bq_wp, bq_rp;
  logic [1:0]        bq_n;

  logic [7:0]        r_left;

  wire aw_hs  = awvalid && awready;
  wire w_hs   = wvalid && wready;
  wire w_done = w_hs && wlast;
  wire b_hs   = bvalid && bready;
  wire ar_hs  = arvalid && arready;
  wire r_hs   = rvalid && rready;

  wire size_ok = WIDE_MODE ? (awsize == 3'd3) : (awsize == 3'd1 || awsize == 3'd2);
  wire aw_ok   = (awlen == 8'd0) && size_ok && (awaddr[15:0] == DOORBELL_OFS)
               && (awsnoop == 4'd0) && !awbar[0];

  wire unused_ok = ^{awaddr[ADDR_W-1:16], awcache, awprot, awdomain, awbar[1], wstrb,
                     araddr, arsize, arcache, arprot, arsnoop, ardomain, arbar};

  assign awready = ({1'b0, aq_n} + {1'b0, bq_n}) < 3'd2;
  assign wready  = aq_n != 2'd0;
  assign bvalid  = bq_n != 2'd0;
  assign bid     = bq_id[bq_rp];
  assign bresp   = 2'b00;
  assign arready = !rvalid;
  assign rdata   = '0;
  assign rresp   = 2'b00;
  assign rlast   = r_left == 8'd0;

  always_ff @(posedge clk) begin
    if (aw_hs) begin
      aq_id[aq_wp]   <= awid;
      aq_ok[aq_wp]   <= aw_ok;
      aq_half[aq_wp] <= awsize == 3'd1;
      aq_dev[aq_wp]  <= awuser[DEV_W-1:0];
      aq_lane[aq_wp] <= awaddr[LANE_W-1:0];
    end
    if (w_done) bq_id[bq_wp] <= aq_id[aq_rp];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aq_wp <= 1'b0; aq_rp <= 1'b0; aq_n <= 2'd0;
      bq_wp <= 1'b0; bq_rp <= 1'b0; bq_n <= 2'd0;
    end else begin
      if (aw_hs)  aq_wp <= ~aq_wp;
      if (w_done) aq_rp <= ~aq_rp;
      aq_n <= aq_n + {1'b0, aw_hs} - {1'b0, w_done};
      if (w_done) bq_wp <= ~bq_wp;
      if (b_hs)   bq_rp <= ~bq_rp;
      bq_n <= bq_n + {1'b0, w_done} - {1'b0, b_hs};
    end
  end

  logic [63:0] lane64;
  assign lane64 = 64'(wdata >> {aq_lane[aq_rp], 3'b000});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid <= 1'b0;
      evt_dev   <= '0;
      evt_id    <= '0;
    end else begin
      evt_valid <= w_done && aq_ok[aq_rp];
      if (w_done && aq_ok[aq_rp]) begin
        if (WIDE_MODE) begin
          evt_dev <= lane64[32 +: DEV_W];
          evt_id  <= lane64[31:0];
        end else begin
          evt_dev <= aq_dev[aq_rp];
          evt_id  <= aq_half[aq_rp] ? {16'h0000, lane64[15:0]} : lane64[31:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rid    <= '0;
      r_left <= 8'd0;
    end else if (ar_hs) begin
      rvalid <= 1'b1;
      rid    <= arid;
      r_left <= arlen;
    end else if (r_hs) begin
      if (r_left == 8'd0) rvalid <= 1'b0;
      else                r_left <= r_left - 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wakeup <= 1'b0;
    else        wakeup <= awvalid || arvalid;
  end
endmodule

// File: rtl/msi_doorbell_port_chk.sv
module msi_doorbell_port_chk #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              awvalid,
  input logic              awready,
  input logic              arvalid,
  input logic              arready,
  input logic              wvalid,
  input logic              wready,
  input logic              wlast,
  input logic              bvalid,
  input logic              bready,
  input logic [ID_W-1:0]   bid,
  input logic [1:0]        bresp,
  input logic              rvalid,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        rresp,
  input logic              evt_valid,
  input logic              wakeup
);
  logic [2:0] open_n;
  always_ff @(posedge clk) begin
    if (!rst_n) open_n <= 3'd0;
    else open_n <= open_n + {2'b0, awvalid && awready} - {2'b0, bvalid && bready};
  end

  p_wr_limit_r7: assert property (@(posedge clk) disable iff (!rst_n) open_n <= 3'd2);
  p_aw_stall_r7: assert property (@(posedge clk) disable iff (!rst_n) open_n == 3'd2 |-> !awready);
  p_rd_single_r8: assert property (@(posedge clk) disable iff (!rst_n) rvalid |-> !arready);
  p_rd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rdata == '0 && rresp == 2'b00));
  p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> wakeup == $past(awvalid || arvalid));
  p_bresp_okay_r10: assert property (@(posedge clk) disable iff (!rst_n) bvalid |-> bresp == 2'b00);
  p_b_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> (bvalid && $stable(bid)));
  p_evt_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && evt_valid) |-> $past(wvalid && wready && wlast));
endmodule

bind msi_doorbell_port msi_doorbell_port_chk #(.ID_W(ID_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .awvalid(awvalid), .awready(awready),
  .arvalid(arvalid), .arready(arready), .wvalid(wvalid), .wready(wready),
  .wlast(wlast), .bvalid(bvalid), .bready(bready), .bid(bid), .bresp(bresp),
  .rvalid(rvalid), .rdata(rdata), .rresp(rresp), .evt_valid(evt_valid),
  .wakeup(wakeup)
);

// File: tb/msi_doorbell_port_tb.sv
module msi_doorbell_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] OFS = 16'h0040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic awvalid = 0, wvalid = 0, wlast = 0, bready = 1, arvalid = 0, rready = 1;
  logic [3:0]  awid = 0, arid = 0;
  logic [31:0] awaddr = 0, araddr = 0, awuser = 0;
  logic [7:0]  awlen = 0, arlen = 0;
  logic [2:0]  awsize = 0, awprot = 0, arsize = 0, arprot = 0;
  logic [3:0]  awcache = 0, awsnoop = 0, arcache = 0, arsnoop = 0;
  logic [1:0]  awdomain = 0, awbar = 0, ardomain = 0, arbar = 0;
  logic [63:0] wdata = 0;
  logic [7:0]  wstrb = 8'hFF;

  logic awready_s, wready_s, bvalid_s, arready_s, rvalid_s, rlast_s, evt_s, wake_s;
  logic awready_w, wready_w, bvalid_w, arready_w, rvalid_w, rlast_w, evt_w, wake_w;
  logic [3:0]  bid_s, bid_w, rid_s, rid_w;
  logic [1:0]  bresp_s, bresp_w, rresp_s, rresp_w;
  logic [63:0] rdata_s, rdata_w;
  logic [31:0] dev_s, dev_w, eid_s, eid_w;

  msi_doorbell_port #(.WIDE_MODE(1'b0), .DOORBELL_OFS(OFS)) u_dut (
    .clk, .rst_n, .awvalid, .awready(awready_s), .awid, .awaddr, .awlen, .awsize,
    .awcache, .awprot, .awsnoop, .awdomain, .awbar, .awuser, .wvalid, .wready(wready_s),
    .wdata, .wstrb, .wlast, .bvalid(bvalid_s), .bready, .bid(bid_s), .bresp(bresp_s),
    .arvalid, .arready(arready_s), .arid, .araddr, .arlen, .arsize, .arcache, .arprot,
    .arsnoop, .ardomain, .arbar, .rvalid(rvalid_s), .rready, .rid(rid_s), .rdata(rdata_s),
    .rresp(rresp_s), .rlast(rlast_s), .evt_valid(evt_s), .evt_dev(dev_s), .evt_id(eid_s),
    .wakeup(wake_s));

  msi_doorbell_port #(.WIDE_MODE(1'b1), .DOORBELL_OFS(OFS)) u_dut_wide (
    .clk, .rst_n, .awvalid, .awready(awready_w), .awid, .awaddr, .awlen, .awsize,
    .awcache, .awprot, .awsnoop, .awdomain, .awbar, .awuser, .wvalid, .wready(wready_w),
    .wdata, .wstrb, .wlast, .bvalid(bvalid_w), .bready, .bid(bid_w), .bresp(bresp_w),
    .arvalid, .arready(arready_w), .arid, .araddr, .arlen, .arsize, .arcache, .arprot,
    .arsnoop, .ardomain, .arbar, .rvalid(rvalid_w), .rready, .rid(rid_w), .rdata(rdata_w),
    .rresp(rresp_w), .rlast(rlast_w), .evt_valid(evt_w), .evt_dev(dev_w), .evt_id(eid_w),
    .wakeup(wake_w));

  int checks = 0, fails = 0;
  int ev_n_s = 0, ev_n_w = 0;
  always @(posedge clk) begin
    if (evt_s) ev_n_s <= ev_n_s + 1;
    if (evt_w) ev_n_w <= ev_n_w + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_fire(bit wide, logic [7:0] len, logic [2:0] sz,
                                  logic [31:0] a, logic [3:0] sn, logic [1:0] br);
    bit szok = wide ? (sz == 3'd3) : (sz == 3'd1 || sz == 3'd2);
    return len == 0 && szok && a[15:0] == OFS && sn == 0 && !br[0];
  endfunction

  function automatic logic [31:0] exp_id(bit wide, logic [2:0] sz, logic [63:0] d);
    if (wide) return d[31:0];
    return (sz == 3'd1) ? {16'h0, d[15:0]} : d[31:0];
  endfunction

  function automatic logic [31:0] exp_dev(bit wide, logic [31:0] u, logic [63:0] d);
    return wide ? d[63:32] : u;
  endfunction

  task automatic wr(input logic [3:0] id, input logic [31:0] a, input logic [7:0] len,
                    input logic [2:0] sz, input logic [3:0] sn, input logic [1:0] br,
                    input logic [31:0] u, input logic [63:0] d);
    int n0s = ev_n_s, n0w = ev_n_w;
    bit fs = exp_fire(1'b0, len, sz, a, sn, br);
    bit fw = exp_fire(1'b1, len, sz, a, sn, br);
    awid = id; awaddr = a; awlen = len; awsize = sz; awsnoop = sn; awbar = br; awuser = u;
    awcache = 4'($urandom); awprot = 3'($urandom); awdomain = 2'($urandom);
    awvalid = 1;
    while (!(awready_s && awready_w)) @(negedge clk);
    @(negedge clk);
    awvalid = 0;
    for (int b = 0; b <= int'(len); b++) begin
      wdata = d << {a[2:0], 3'b000};
      wvalid = 1; wlast = (b == int'(len));
      while (!(wready_s && wready_w)) @(negedge clk);
      @(negedge clk);
      if (b == int'(len)) begin
        chk(evt_s == fs, "R1 evt pulse sideband", 64'(evt_s), 64'(fs));
        chk(evt_w == fw, "R1 evt pulse wide", 64'(evt_w), 64'(fw));
        if (fs) begin
          chk(dev_s == exp_dev(1'b0, u, d), "R3 dev sideband", 64'(dev_s), 64'(exp_dev(1'b0, u, d)));
          chk(eid_s == exp_id(1'b0, sz, d), "R3 id sideband", 64'(eid_s), 64'(exp_id(1'b0, sz, d)));
        end
        if (fw) begin
          chk(dev_w == exp_dev(1'b1, u, d), "R2 dev wide", 64'(dev_w), 64'(exp_dev(1'b1, u, d)));
          chk(eid_w == exp_id(1'b1, sz, d), "R2 id wide", 64'(eid_w), 64'(exp_id(1'b1, sz, d)));
        end
      end
    end
    wvalid = 0; wlast = 0;
    while (!(bvalid_s && bvalid_w)) @(negedge clk);
    chk(bid_s == id && bid_w == id, "R10 bid", 64'({bid_s, bid_w}), 64'({id, id}));
    chk(bresp_s == 0 && bresp_w == 0, "R10 bresp okay", 64'({bresp_s, bresp_w}), 64'(0));
    @(negedge clk);
    chk(ev_n_s - n0s == int'(fs), "R4 event count sideband", 64'(ev_n_s - n0s), 64'(fs));
    chk(ev_n_w - n0w == int'(fw), "R4 event count wide", 64'(ev_n_w - n0w), 64'(fw));
  endtask

  task automatic rd(input logic [3:0] id, input logic [7:0] len);
    int n0s = ev_n_s, n0w = ev_n_w;
    arid = id; arlen = len; araddr = $urandom; arsnoop = 4'($urandom); arbar = 2'($urandom);
    arcache = 4'($urandom); arprot = 3'($urandom); ardomain = 2'($urandom); arsize = 3'($urandom);
    arvalid = 1;
    while (!(arready_s && arready_w)) @(negedge clk);
    @(negedge clk);
    arvalid = 0;
    for (int b = 0; b <= int'(len); b++) begin
      while (!(rvalid_s && rvalid_w)) @(negedge clk);
      chk(rdata_s == 0 && rdata_w == 0 && rresp_s == 0 && rresp_w == 0, "R8 zero okay data",
          rdata_s | rdata_w, 64'(0));
      chk(rid_s == id && rid_w == id, "R8 rid", 64'({rid_s, rid_w}), 64'({id, id}));
      chk(rlast_s == (b == int'(len)) && rlast_w == rlast_s, "R8 rlast",
          64'({rlast_s, rlast_w}), 64'(b == int'(len)));
      chk(!arready_s && !arready_w, "R8 single read", 64'({arready_s, arready_w}), 64'(0));
      @(negedge clk);
    end
    chk(ev_n_s == n0s && ev_n_w == n0w, "R8 no event on read", 64'(ev_n_s - n0s), 64'(0));
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(awready_s && awready_w, "R11 awready", 64'({awready_s, awready_w}), 64'(3));
    chk(!bvalid_s && !rvalid_s && !evt_s && !wake_s, "R11 idle sideband",
        64'({bvalid_s, rvalid_s, evt_s, wake_s}), 64'(0));
    chk(!bvalid_w && !rvalid_w && !evt_w && !wake_w, "R11 idle wide",
        64'({bvalid_w, rvalid_w, evt_w, wake_w}), 64'(0));

    // R3 sideband word and half; R2 wide
    wr(4'h1, {16'h0000, OFS}, 0, 3'd2, 0, 0, 32'hCAFE_0001, 64'h1111_2222_3333_4444);
    wr(4'h2, {16'h0000, OFS}, 0, 3'd1, 0, 0, 32'hCAFE_0002, 64'h5555_6666_7777_ABCD);
    wr(4'h3, {16'h0000, OFS}, 0, 3'd3, 0, 0, 32'hCAFE_0003, 64'hDEAD_BEEF_0000_0042);
    // R5 upper bits ignored, other offset rejected
    wr(4'h4, {16'hABCD, OFS}, 0, 3'd3, 0, 0, 32'h0, 64'h0000_0077_0000_0099);
    wr(4'h5, {16'h0000, OFS + 16'd8}, 0, 3'd2, 0, 0, 32'h1, 64'h12);
    // R4 burst and wrong size
    wr(4'h6, {16'h0000, OFS}, 3, 3'd2, 0, 0, 32'h2, 64'h34);
    wr(4'h7, {16'h0000, OFS}, 0, 3'd0, 0, 0, 32'h3, 64'h56);
    // R6 barrier and snoop
    wr(4'h8, {16'h0000, OFS}, 0, 3'd3, 0, 2'b01, 32'h4, 64'h78);
    wr(4'h9, {16'h0000, OFS}, 0, 3'd2, 4'h3, 0, 32'h5, 64'h9A);

    // R9 wakeup
    chk(!wake_s && !wake_w, "R9 wakeup idle", 64'({wake_s, wake_w}), 64'(0));
    arid = 4'hA; arlen = 0; arvalid = 1;
    @(negedge clk);
    chk(wake_s && wake_w, "R9 wakeup follows valid", 64'({wake_s, wake_w}), 64'(3));
    arvalid = 0;
    @(negedge clk);
    chk(!wake_s && !wake_w, "R9 wakeup drops", 64'({wake_s, wake_w}), 64'(0));
    while (rvalid_s) @(negedge clk);

    // R8 reads
    rd(4'hB, 0);
    rd(4'hC, 3);

    // R7 / R10 two outstanding, ordered responses
    bready = 0;
    awlen = 0; awsize = 3'd2; awaddr = {16'h0, OFS}; awsnoop = 0; awbar = 0;
    awid = 4'h1; awvalid = 1;
    while (!awready_s) @(negedge clk);
    @(negedge clk);
    awid = 4'h2;
    while (!awready_s) @(negedge clk);
    @(negedge clk);
    awid = 4'h3;
    chk(!awready_s && !awready_w, "R7 third address stalled", 64'({awready_s, awready_w}), 64'(0));
    wdata = 64'h10; wvalid = 1; wlast = 1;
    @(negedge clk);
    @(negedge clk);
    wvalid = 0; wlast = 0;
    chk(!awready_s && !awready_w, "R7 still stalled with responses pending",
        64'({awready_s, awready_w}), 64'(0));
    chk(bvalid_s && bid_s == 4'h1, "R10 first response id", 64'(bid_s), 64'(1));
    @(negedge clk);
    chk(bvalid_s && bid_s == 4'h1, "R10 response held", 64'(bid_s), 64'(1));
    bready = 1;
    @(negedge clk);
    chk(bvalid_s && bid_s == 4'h2 && bid_w == 4'h2, "R10 second response id", 64'(bid_s), 64'(2));
    chk(awready_s && awready_w, "R7 slot freed", 64'({awready_s, awready_w}), 64'(3));
    @(negedge clk);
    awvalid = 0;
    wvalid = 1; wlast = 1;
    while (!wready_s) @(negedge clk);
    @(negedge clk);
    wvalid = 0; wlast = 0;
    while (!bvalid_s) @(negedge clk);
    chk(bid_s == 4'h3, "R10 third response id", 64'(bid_s), 64'(3));
    @(negedge clk);

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      logic [7:0]  len;
      logic [2:0]  sz;
      logic [3:0]  sn;
      int k = $urandom_range(0, 9);
      a   = {16'($urandom), (k < 7) ? OFS : 16'($urandom)};
      len = ($urandom_range(0, 5) == 0) ? 8'($urandom_range(1, 3)) : 8'd0;
      sz  = 3'($urandom_range(0, 4));
      sn  = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'd0;
      if (sz == 3'd3) a[2:0] = 3'd0;
      if ($urandom_range(0, 15) == 0) rd(4'($urandom), 8'($urandom_range(0, 4)));
      wr(4'($urandom), a, len, sz, sn, 2'($urandom_range(0, 3) == 0 ? 1 : 0),
         $urandom, {$urandom, $urandom});
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule